// File: doc/BRIEF.md
# Port Status LED Driver

This block turns per-port status flags of a five-port repeater into twelve active-low LED drive lines. Four of the ports are twisted-pair ports and one is an AUI port. Each port has a pin in bank A and a pin in bank B. Two global pins summarise the banks across all ports. A pin is released (driven high) when nothing it shows is true, and pulled low when a shown attribute is true.

A 3-bit display code picks the attribute, or the pair of attributes, that each bank shows. A pair always consists of one solid attribute and one blinking attribute. While the blinking attribute is true it owns the pin, and the pin follows a shared blink phase. All blinking pins take that phase from a single counter of millisecond ticks, so they stay in step with each other. Carrier and collision events are short, so each one is held for a programmable number of ticks after it ends. This keeps brief activity visible.

Display code table (bank A solid / bank A blink / bank B solid / bank B blink):
`000` carrier / - / collision / - ; `001` link / - / partition / - ; `010` loopback / - / disabled / - ; `011` jabber / - / collision / - ; `100` carrier / - / link / - ; `101` link / collision / disabled / jabber ; `110` link or partition / carrier / partition / collision ; `111` nothing shown.

Top module: `led_status_driver`

## Requirements
- R1: While reset is held and right after it is released, all twelve outputs are 1 (released).
- R2: An output bit of 1 means released and a bit of 0 means lit. A change on a non-stretched status input is seen at the outputs exactly 2 clock cycles after the edge that samples it, and the outputs keep their old value for the cycle in between.
- R3: Codes `000` to `100` show a steady low on each pin whose single selected attribute (as in the table) is true, and they show no other attribute.
- R4: Code `101` shows link solid with collision blinking in bank A, and disabled solid with jabber blinking in bank B.
- R5: Code `110` shows link or partition solid with carrier blinking in bank A, and partition solid with collision blinking in bank B.
- R6: Code `111` releases all twelve outputs, whatever the status inputs are.
- R7: While a pin's blinking attribute is true, the pin follows the blink phase: low in the lit half and released in the dark half. This holds even when the pin's solid attribute is true.
- R8: The blink phase is dark after reset. It toggles once every BLINK_HALF_MS millisecond ticks and never toggles without a tick. All pins share this one phase.
- R9: A carrier or collision pulse of any length keeps the attribute true until STRETCH_MS ticks have followed the last cycle in which the input was high.
- R10: The link flag of a port whose index is NUM_TP or above (the AUI port, index 4) is ignored in every code.
- R11: Global pin A (B) is low, steadily and without blinking, when any port has its bank A (B) solid or blinking attribute true. Otherwise it is released.
- R12: A change of display code reaches the outputs with the same 2-cycle latency as a status change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick_i | input | 1 | One-cycle pulse every millisecond |
| mode_i | input | 3 | Display code |
| carrier_i | input | NUM_PORTS | Carrier sense per port |
| collision_i | input | NUM_PORTS | Collision per port |
| partition_i | input | NUM_PORTS | Partitioned per port |
| link_i | input | NUM_PORTS | Link up per port (ignored for AUI) |
| loopback_i | input | NUM_PORTS | Loopback per port |
| disabled_i | input | NUM_PORTS | Port disabled |
| jabber_i | input | NUM_PORTS | Jabber per port |
| led_a_n_o | output | NUM_PORTS | Bank A pins, low = lit |
| led_b_n_o | output | NUM_PORTS | Bank B pins, low = lit |
| led_ga_n_o | output | 1 | Global bank A pin, low = lit |
| led_gb_n_o | output | 1 | Global bank B pin, low = lit |

## Verification
The status inputs and the display code pass through one capture register and then one output register. Each expected value is therefore queued to fall due 2 cycles after the negative edge at which the stimulus is applied. Probe steps queue the old pattern for the cycle in between as well, so a result that arrives a cycle early or a cycle late is caught. The blink phase moves only on ticks, and only one register lies between the phase and the pins. For that reason the blink and stretch checks are queued only after the tick pulses have stopped and two further cycles have passed. Expected phases and stretch expiries are counted from the ticks the bench itself issues.

// File: rtl/led_pkg.sv
package led_pkg;

   typedef enum logic [2:0] {
      MODE_ACT_COL    = 3'b000,
      MODE_LINK_PART  = 3'b001,
      MODE_LOOP_DIS   = 3'b010,
      MODE_JAB_COL    = 3'b011,
      MODE_ACT_LINK   = 3'b100,
      MODE_LINK_BLINK = 3'b101,
      MODE_COMBO      = 3'b110,
      MODE_DARK       = 3'b111
   } led_mode_e;

endpackage

// File: rtl/led_event_stretch.sv
module led_event_stretch #(
   parameter int NUM_PORTS = 5,
   parameter int HOLD_MS   = 130
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_i,
   input  logic [NUM_PORTS-1:0] raw_i,
   output logic [NUM_PORTS-1:0] act_o
);

   localparam int CW = $clog2(HOLD_MS + 1);
   localparam logic [CW-1:0] LOAD = CW'(HOLD_MS);

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (raw_i[p]) begin
            cnt_q <= LOAD;
         end else if (tick_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end

      assign act_o[p] = (cnt_q != '0);

      // R9
      stretch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         raw_i[p] |=> act_o[p]);

      // R9
      stretch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (act_o[p] && !tick_i) |=> act_o[p]);
   end

endmodule

// File: rtl/led_blink_gen.sv
module led_blink_gen #(
   parameter int HALF_MS = 65
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   output logic phase_o
);

   localparam int CW = (HALF_MS > 1) ? $clog2(HALF_MS) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_MS - 1);

   logic [CW-1:0] cnt_q;
   logic          phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         phase_q <= 1'b0;
      end else if (tick_i) begin
         if (cnt_q == LAST) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign phase_o = phase_q;

   // R8
   phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(phase_o));

endmodule

// File: rtl/led_bank_select.sv
module led_bank_select #(
   parameter int NUM_PORTS = 5
) (
   input  led_pkg::led_mode_e   mode_i,
   input  logic [NUM_PORTS-1:0] carrier_i,
   input  logic [NUM_PORTS-1:0] collision_i,
   input  logic [NUM_PORTS-1:0] partition_i,
   input  logic [NUM_PORTS-1:0] link_i,
   input  logic [NUM_PORTS-1:0] loopback_i,
   input  logic [NUM_PORTS-1:0] disabled_i,
   input  logic [NUM_PORTS-1:0] jabber_i,
   output logic [NUM_PORTS-1:0] a_solid_o,
   output logic [NUM_PORTS-1:0] a_blink_o,
   output logic [NUM_PORTS-1:0] b_solid_o,
   output logic [NUM_PORTS-1:0] b_blink_o
);

   import led_pkg::*;

   always_comb begin
      a_solid_o = '0;
      a_blink_o = '0;
      b_solid_o = '0;
      b_blink_o = '0;
      unique case (mode_i)
         MODE_ACT_COL: begin
            a_solid_o = carrier_i;
            b_solid_o = collision_i;
         end
         MODE_LINK_PART: begin
            a_solid_o = link_i;
            b_solid_o = partition_i;
         end
         MODE_LOOP_DIS: begin
            a_solid_o = loopback_i;
            b_solid_o = disabled_i;
         end
         MODE_JAB_COL: begin
            a_solid_o = jabber_i;
            b_solid_o = collision_i;
         end
         MODE_ACT_LINK: begin
            a_solid_o = carrier_i;
            b_solid_o = link_i;
         end
         MODE_LINK_BLINK: begin
            a_solid_o = link_i;
            a_blink_o = collision_i;
            b_solid_o = disabled_i;
            b_blink_o = jabber_i;
         end
         MODE_COMBO: begin
            a_solid_o = link_i | partition_i;
            a_blink_o = carrier_i;
            b_solid_o = partition_i;
            b_blink_o = collision_i;
         end
         MODE_DARK: begin
            a_solid_o = '0;
         end
         default: begin
            a_solid_o = '0;
         end
      endcase
   end

endmodule

// File: rtl/led_pin_drive.sv
module led_pin_drive #(
   parameter int NUM_PORTS = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 phase_i,
   input  logic [NUM_PORTS-1:0] a_solid_i,
   input  logic [NUM_PORTS-1:0] a_blink_i,
   input  logic [NUM_PORTS-1:0] b_solid_i,
   input  logic [NUM_PORTS-1:0] b_blink_i,
   output logic [NUM_PORTS-1:0] led_a_n_o,
   output logic [NUM_PORTS-1:0] led_b_n_o,
   output logic                 led_ga_n_o,
   output logic                 led_gb_n_o
);

   logic [NUM_PORTS-1:0] a_lit, b_lit;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pin
      assign a_lit[p] = a_blink_i[p] ? phase_i : a_solid_i[p];
      assign b_lit[p] = b_blink_i[p] ? phase_i : b_solid_i[p];

      // R7
      blink_prio_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (a_blink_i[p] && !phase_i) |=> led_a_n_o[p]);

      // R7
      blink_lit_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (b_blink_i[p] && phase_i) |=> !led_b_n_o[p]);

      // R2
      solid_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (a_solid_i[p] && !a_blink_i[p]) |=> !led_a_n_o[p]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         led_a_n_o  <= '1;
         led_b_n_o  <= '1;
         led_ga_n_o <= 1'b1;
         led_gb_n_o <= 1'b1;
      end else begin
         led_a_n_o  <= ~a_lit;
         led_b_n_o  <= ~b_lit;
         led_ga_n_o <= ~|(a_solid_i | a_blink_i);
         led_gb_n_o <= ~|(b_solid_i | b_blink_i);
      end
   end

   // R11
   global_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(a_solid_i | a_blink_i)) |=> !led_ga_n_o);

   // R11
   global_b_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(b_solid_i | b_blink_i)) |=> led_gb_n_o);

endmodule

// File: rtl/led_status_driver.sv
module led_status_driver #(
   parameter int NUM_PORTS     = 5,
   parameter int NUM_TP        = 4,
   parameter int BLINK_HALF_MS = 65,
   parameter int STRETCH_MS    = 130
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ms_tick_i,
   input  logic [2:0]           mode_i,
   input  logic [NUM_PORTS-1:0] carrier_i,
   input  logic [NUM_PORTS-1:0] collision_i,
   input  logic [NUM_PORTS-1:0] partition_i,
   input  logic [NUM_PORTS-1:0] link_i,
   input  logic [NUM_PORTS-1:0] loopback_i,
   input  logic [NUM_PORTS-1:0] disabled_i,
   input  logic [NUM_PORTS-1:0] jabber_i,
   output logic [NUM_PORTS-1:0] led_a_n_o,
   output logic [NUM_PORTS-1:0] led_b_n_o,
   output logic                 led_ga_n_o,
   output logic                 led_gb_n_o
);

   import led_pkg::*;

   if (NUM_PORTS < 1) begin : g_bad_ports
      $error("led_status_driver: NUM_PORTS must be at least 1");
   end
   if ((NUM_TP < 0) || (NUM_TP > NUM_PORTS)) begin : g_bad_tp
      $error("led_status_driver: NUM_TP must lie in 0..NUM_PORTS");
   end
   if (BLINK_HALF_MS < 1) begin : g_bad_half
      $error("led_status_driver: BLINK_HALF_MS must be at least 1");
   end
   if (STRETCH_MS < 2 * BLINK_HALF_MS) begin : g_bad_stretch
      $error("led_status_driver: STRETCH_MS must cover one full blink period");
   end

   logic [NUM_PORTS-1:0] tp_mask;
   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_mask
      if (p < NUM_TP) begin : g_tp
         assign tp_mask[p] = 1'b1;
      end else begin : g_aui
         assign tp_mask[p] = 1'b0;
      end
   end

   led_mode_e            mode_q;
   logic [NUM_PORTS-1:0] part_q, link_q, loop_q, dis_q, jab_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_ACT_COL;
         part_q <= '0;
         link_q <= '0;
         loop_q <= '0;
         dis_q  <= '0;
         jab_q  <= '0;
      end else begin
         mode_q <= led_mode_e'(mode_i);
         part_q <= partition_i;
         link_q <= link_i & tp_mask;
         loop_q <= loopback_i;
         dis_q  <= disabled_i;
         jab_q  <= jabber_i;
      end
   end

   logic [NUM_PORTS-1:0] car_act, col_act;

   led_event_stretch #(.NUM_PORTS(NUM_PORTS), .HOLD_MS(STRETCH_MS)) u_car_stretch (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (ms_tick_i),
      .raw_i  (carrier_i),
      .act_o  (car_act)
   );

   led_event_stretch #(.NUM_PORTS(NUM_PORTS), .HOLD_MS(STRETCH_MS)) u_col_stretch (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (ms_tick_i),
      .raw_i  (collision_i),
      .act_o  (col_act)
   );

   logic phase;

   led_blink_gen #(.HALF_MS(BLINK_HALF_MS)) u_blink (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (ms_tick_i),
      .phase_o (phase)
   );

   logic [NUM_PORTS-1:0] a_solid, a_blink, b_solid, b_blink;

   led_bank_select #(.NUM_PORTS(NUM_PORTS)) u_select (
      .mode_i      (mode_q),
      .carrier_i   (car_act),
      .collision_i (col_act),
      .partition_i (part_q),
      .link_i      (link_q),
      .loopback_i  (loop_q),
      .disabled_i  (dis_q),
      .jabber_i    (jab_q),
      .a_solid_o   (a_solid),
      .a_blink_o   (a_blink),
      .b_solid_o   (b_solid),
      .b_blink_o   (b_blink)
   );

   led_pin_drive #(.NUM_PORTS(NUM_PORTS)) u_drive (
      .clk        (clk),
      .rst_n      (rst_n),
      .phase_i    (phase),
      .a_solid_i  (a_solid),
      .a_blink_i  (a_blink),
      .b_solid_i  (b_solid),
      .b_blink_i  (b_blink),
      .led_a_n_o  (led_a_n_o),
      .led_b_n_o  (led_b_n_o),
      .led_ga_n_o (led_ga_n_o),
      .led_gb_n_o (led_gb_n_o)
   );

   // R6
   dark_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_DARK) |=> ((&led_a_n_o) && (&led_b_n_o) && led_ga_n_o && led_gb_n_o));

   // R10
   aui_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_LINK_PART) |-> ((link_q & ~tp_mask) == '0));

endmodule

// File: tb/led_status_driver_bench.sv
module led_status_driver_bench;

   localparam int HALF = 3;
   localparam int HOLD = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ms_tick = 1'b0;
   logic [2:0] mode = 3'b000;
   logic [4:0] car = '0, col = '0, par = '0, lnk = '0, lpb = '0, dis = '0, jab = '0;
   logic [4:0] led_a_n, led_b_n;
   logic       led_ga_n, led_gb_n;
   logic [11:0] obs;

   always #5 clk = ~clk;

   led_status_driver #(
      .NUM_PORTS(5), .NUM_TP(4), .BLINK_HALF_MS(HALF), .STRETCH_MS(HOLD)
   ) u_led_status_driver (
      .clk (clk), .rst_n (rst_n), .ms_tick_i (ms_tick), .mode_i (mode),
      .carrier_i (car), .collision_i (col), .partition_i (par), .link_i (lnk),
      .loopback_i (lpb), .disabled_i (dis), .jabber_i (jab),
      .led_a_n_o (led_a_n), .led_b_n_o (led_b_n),
      .led_ga_n_o (led_ga_n), .led_gb_n_o (led_gb_n)
   );

   assign obs = {led_gb_n, led_ga_n, led_b_n, led_a_n};

   typedef struct {
      int          due;
      logic [11:0] exp;
      string       tag;
   } item_t;

   item_t sb[$];
   int    cyc = 0;
   int    n_cmp = 0;
   int    n_bad = 0;
   int    ticks = 0;
   bit    done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // Monitor: compares each queued expectation in the cycle it falls due
   always @(negedge clk) begin : mon
      item_t it;
      while (sb.size() > 0 && sb[0].due <= cyc) begin
         it = sb.pop_front();
         n_cmp++;
         if (it.due != cyc || obs !== it.exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b (due %0d, now %0d)",
                     it.tag, obs, it.exp, it.due, cyc);
         end
      end
   end

   function automatic bit phase_now();
      return ((ticks / HALF) % 2) == 1;
   endfunction

   function automatic logic [11:0] ref_out(
      input logic [2:0] m, input logic [4:0] c_car, c_col, c_par, c_lnk, c_lpb, c_dis, c_jab,
      input bit ph);
      logic [4:0] ln, as, ab, bs, bb, al, bl;
      ln = c_lnk & 5'b01111;
      as = '0; ab = '0; bs = '0; bb = '0;
      case (m)
         3'b000: begin as = c_car; bs = c_col; end
         3'b001: begin as = ln;    bs = c_par; end
         3'b010: begin as = c_lpb; bs = c_dis; end
         3'b011: begin as = c_jab; bs = c_col; end
         3'b100: begin as = c_car; bs = ln;    end
         3'b101: begin as = ln; ab = c_col; bs = c_dis; bb = c_jab; end
         3'b110: begin as = ln | c_par; ab = c_car; bs = c_par; bb = c_col; end
         default: begin as = '0; end
      endcase
      al = (ab & {5{ph}}) | (as & ~ab);
      bl = (bb & {5{ph}}) | (bs & ~bb);
      return {~|(bs | bb), ~|(as | ab), ~bl, ~al};
   endfunction

   function automatic logic [11:0] ref_now();
      return ref_out(mode, car, col, par, lnk, lpb, dis, jab, phase_now());
   endfunction

   task automatic push_exp(input int lat, input logic [11:0] e, input string tag);
      item_t it;
      it.due = cyc + lat;
      it.exp = e;
      it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic set_in(input logic [2:0] m, input logic [4:0] a, b, c, d, e, f, g);
      mode = m; car = a; col = b; par = c; lnk = d; lpb = e; dis = f; jab = g;
   endtask

   // Driver: apply stimulus, expectation due two cycles later
   task automatic apply(input logic [2:0] m, input logic [4:0] a, b, c, d, e, f, g,
                        input string tag);
      @(negedge clk);
      set_in(m, a, b, c, d, e, f, g);
      push_exp(2, ref_now(), tag);
      repeat (3) @(negedge clk);
   endtask

   // Driver: old pattern one cycle later, new pattern two cycles later
   task automatic probe(input logic [2:0] m, input logic [4:0] a, b, c, d, e, f, g,
                        input string tag);
      logic [11:0] e_old;
      @(negedge clk);
      e_old = ref_now();
      set_in(m, a, b, c, d, e, f, g);
      push_exp(1, e_old, tag);
      push_exp(2, ref_now(), tag);
      repeat (3) @(negedge clk);
   endtask

   task automatic tick_n(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) ms_tick = 1'b1;
         @(negedge clk) ms_tick = 1'b0;
         ticks++;
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic hold(input string tag);
      push_exp(1, ref_now(), tag);
      repeat (2) @(negedge clk);
   endtask

   task automatic flush();
      @(negedge clk);
      set_in(mode, '0, '0, '0, '0, '0, '0, '0);
      tick_n(HOLD);
      hold("R9 stretched events expired");
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : driver
      repeat (4) @(negedge clk);
      // R1: outputs released during reset
      push_exp(0, 12'hFFF, "R1 during reset");
      @(negedge clk) rst_n = 1'b1;
      hold("R1 after reset");

      // R3: code 000 carrier / collision
      apply(3'b000, 5'b00101, 5'b10000, '0, '0, '0, '0, '0, "R3 code 000");
      flush();
      // R3: code 001 link / partition
      apply(3'b001, '0, '0, 5'b00010, 5'b01111, '0, '0, '0, "R3 code 001");
      // R10 and R2: AUI link ignored, latency of a status change
      probe(3'b001, '0, '0, '0, 5'b10000, '0, '0, '0, "R10 R2 AUI link ignored");
      // R12: code change together with status change
      probe(3'b010, '0, '0, '0, '0, 5'b00011, 5'b11000, '0, "R12 R3 code 010");
      apply(3'b011, '0, 5'b01000, '0, '0, '0, '0, 5'b00100, "R3 code 011");
      flush();
      apply(3'b100, 5'b10001, '0, '0, 5'b11111, '0, '0, '0, "R3 R10 code 100");
      flush();

      // R4 R7: code 101, blink attribute wins in dark phase
      apply(3'b101, '0, 5'b00010, '0, 5'b11111, '0, 5'b00001, 5'b00001, "R4 R7 code 101 dark");
      tick_n(HALF);
      hold("R8 R4 phase lit after half period");
      tick_n(HALF - 1);
      hold("R8 phase held before next half");
      tick_n(1);
      hold("R8 phase dark again");
      flush();

      // R5: code 110 combined display
      apply(3'b110, 5'b00001, 5'b00100, 5'b00100, 5'b00001, '0, '0, '0, "R5 R11 code 110 dark");
      tick_n(HALF);
      hold("R5 R7 code 110 lit");
      flush();

      // R6: dark code masks everything
      apply(3'b111, '1, '1, '1, '1, '1, '1, '1, "R6 code 111");
      flush();

      // R9: one-cycle carrier pulse stretched
      @(negedge clk);
      mode = 3'b000;
      car = 5'b01000;
      @(negedge clk) car = '0;
      repeat (2) @(negedge clk);
      push_exp(1, ref_out(3'b000, 5'b01000, '0, '0, '0, '0, '0, '0, 1'b0), "R9 pulse visible");
      repeat (2) @(negedge clk);
      tick_n(HOLD - 1);
      push_exp(1, ref_out(3'b000, 5'b01000, '0, '0, '0, '0, '0, '0, 1'b0), "R9 still held");
      repeat (2) @(negedge clk);
      tick_n(1);
      push_exp(1, 12'hFFF, "R9 released after hold");
      repeat (4) @(negedge clk);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule